// File: doc/BRIEF.md
# Software-Assisted Synchronous Serial Line Controller

The block gives firmware direct control of two open-drain serial lines. One line is the clock (S0) and the other is the data line (S1). Firmware writes a control bit for each line. A 0 pulls the pad low and a 1 releases it. Reading a line register returns the level actually sampled on the pin, so a pin held low by another device reads 0 even while its control bit is 1.

The hardware helps the software protocol in four ways:
- On every S0 rising edge it stores the S1 level in a buffer register, which firmware uses when receiving.
- It flags S0 rising edges in a status register.
- It flags a conditional event on S1: S1 changes while S0 is steady high, with a selectable polarity.
- It can hold S0 low after an S0 falling edge, either always or only when the conditional flag is pending. This stretches the clock until firmware releases it.

An enable bit hands the two pads from the ordinary port logic to this block. Pin inputs pass through a synchronizer. The status flags are sticky and are cleared by writing 1. The set condition wins over a clear in the same cycle.

Top module: `ssl_ctrl`

## Requirements
- R1: After reset, both line control bits are 1 and both lines are released. The control register (address 3) reads 0 and the status register (address 4) reads 0.
- R2: While enabled, writing bit0=0 to address 1 (S0) or address 0 (S1) drives that pad low: pad_oe bit set and pad_do bit 0. Bit 0 of pad_oe/pad_do is S0 and bit 1 is S1. Writing bit0=1 releases the pad (pad_oe bit 0).
- R3: Reading address 0 or 1 returns the synchronized pin level in bit0, not the control bit. Bits 7:1 read 0.
- R4: While enabled, each S0 rising edge stores the S1 pin level. The stored value reads at address 2 bit0.
- R5: While enabled, an S0 rising edge sets status bit0. The bit stays set until 1 is written to status bit0. If a set and a clear fall in the same cycle, the set wins.
- R6: While enabled, an S1 transition while S0 is high sets status bit1. Control bit5 picks the polarity: 0 means S1 falling and 1 means S1 rising. S1 changes while S0 is low set nothing.
- R7: With control bit1 set, an S0 falling edge sets status bit2 and holds S0 low, whatever level the external side drives.
- R8: With control bit2 set and control bit1 clear, an S0 falling edge stretches only if status bit1 is already set.
- R9: The stretch ends when 1 is written to address 1 bit0 or to status bit2.
- R10: irq equals (status bit0 AND control bit3) OR (status bit1 AND control bit4).
- R11: With control bit0 = 0, pad_oe and pad_do follow port_oe and port_do, and no status flag or buffer changes. With control bit0 = 1, pad_do is 0 and the pads are driven by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| s0_pin | input | 1 | Level on the S0 clock pad |
| s1_pin | input | 1 | Level on the S1 data pad |
| port_oe | input | 2 | Ordinary port output enables used while disabled |
| port_do | input | 2 | Ordinary port output data used while disabled |
| pad_oe | output | 2 | Pad output enables (bit0 S0, bit1 S1) |
| pad_do | output | 2 | Pad output data |
| irq | output | 1 | Interrupt request |

## Verification
The risky same-cycle case is a status set and a firmware clear landing on the same edge. The bench raises S0 and counts the synchronizer and edge-register delays. It then times a write-1 to status bit0 so that it hits the same clock edge on which the rising-edge flag is set. The flag must read 1 afterwards, and a later lone write-1 must clear it. A second overlap involves the stretch: the bench releases S0 externally while the stretch holds it. S0 must keep reading low until a release write arrives.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 6;

    localparam logic [ADDR_W-1:0] A_S1   = 3'd0;
    localparam logic [ADDR_W-1:0] A_S0   = 3'd1;
    localparam logic [ADDR_W-1:0] A_BUF  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    localparam int CB_EN       = 0;
    localparam int CB_STR_FALL = 1;
    localparam int CB_STR_COND = 2;
    localparam int CB_IRQ_RISE = 3;
    localparam int CB_IRQ_COND = 4;
    localparam int CB_COND_POL = 5;

    localparam int SB_RISE    = 0;
    localparam int SB_COND    = 1;
    localparam int SB_STRETCH = 2;

    typedef struct packed {
        logic              s0_ctl;
        logic              s1_ctl;
        logic [CTRL_W-1:0] ctrl;
        logic              rise_flag;
        logic              cond_flag;
        logic              stretch;
        logic              buf_s1;
    } regs_t;

    typedef struct packed {
        logic s0;
        logic s1;
    } lines_t;
endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st_d [STAGES];
    logic [WIDTH-1:0] st_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb st_d[g] = d;
        end else begin : g_next
            always_comb st_d[g] = st_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/ssl_edge.sv
module ssl_edge
    import ssl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s0,
    input  logic s1,
    input  logic cond_pol,
    output logic s0_rise,
    output logic s0_fall,
    output logic cond_hit
);
    lines_t prev_d, prev_q;
    logic   s1_sel_edge;

    always_comb begin
        prev_d.s0   = s0;
        prev_d.s1   = s1;
        s0_rise     = s0 & ~prev_q.s0;
        s0_fall     = ~s0 & prev_q.s0;
        s1_sel_edge = cond_pol ? (s1 & ~prev_q.s1) : (~s1 & prev_q.s1);
        cond_hit    = s1_sel_edge & s0 & prev_q.s0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{s0: 1'b1, s1: 1'b1};
        else        prev_q <= prev_d;
    end

    AST_COND_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cond_hit |-> $past(s0) && s0) else $error("cond while S0 low"); // R6
endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
    import ssl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              s0_pin,
    input  logic              s1_pin,
    input  logic [1:0]        port_oe,
    input  logic [1:0]        port_do,
    output logic [1:0]        pad_oe,
    output logic [1:0]        pad_do,
    output logic              irq
);
    localparam int PAD_CTRL = DATA_W - CTRL_W;
    localparam int PAD_LINE = DATA_W - 1;
    localparam int PAD_STAT = DATA_W - 3;

    regs_t  r_d, r_q;
    lines_t sync_l;
    logic   s0_rise, s0_fall, cond_hit;
    logic   en, wr_s0, wr_s1, wr_ctrl, wr_stat, release_req;
    logic   unused_wbits;

    ssl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({s0_pin, s1_pin}), .q({sync_l.s0, sync_l.s1})
    );

    ssl_edge edge_i (
        .clk(clk), .rst_n(rst_n), .s0(sync_l.s0), .s1(sync_l.s1),
        .cond_pol(r_q.ctrl[CB_COND_POL]),
        .s0_rise(s0_rise), .s0_fall(s0_fall), .cond_hit(cond_hit)
    );

    assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_W];

    always_comb begin
        en          = r_q.ctrl[CB_EN];
        wr_s1       = bus_we && (bus_addr == A_S1);
        wr_s0       = bus_we && (bus_addr == A_S0);
        wr_ctrl     = bus_we && (bus_addr == A_CTRL);
        wr_stat     = bus_we && (bus_addr == A_STAT);
        release_req = (wr_s0 && bus_wdata[0]) || (wr_stat && bus_wdata[SB_STRETCH]);

        r_d = r_q;
        if (wr_s1)   r_d.s1_ctl = bus_wdata[0];
        if (wr_s0)   r_d.s0_ctl = bus_wdata[0];
        if (wr_ctrl) r_d.ctrl   = bus_wdata[CTRL_W-1:0];
        if (wr_stat && bus_wdata[SB_RISE]) r_d.rise_flag = 1'b0;
        if (wr_stat && bus_wdata[SB_COND]) r_d.cond_flag = 1'b0;
        if (release_req) r_d.stretch = 1'b0;

        // sets take priority over same-cycle clears
        if (en && s0_rise) begin
            r_d.rise_flag = 1'b1;
            r_d.buf_s1    = sync_l.s1;
        end
        if (en && cond_hit) r_d.cond_flag = 1'b1;
        if (en && s0_fall &&
            (r_q.ctrl[CB_STR_FALL] || (r_q.ctrl[CB_STR_COND] && r_q.cond_flag)))
            r_d.stretch = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s0_ctl: 1'b1, s1_ctl: 1'b1, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        if (en) begin
            pad_oe = {~r_q.s1_ctl, ~r_q.s0_ctl | r_q.stretch};
            pad_do = 2'b00;
        end else begin
            pad_oe = port_oe;
            pad_do = port_do;
        end
        irq = (r_q.rise_flag & r_q.ctrl[CB_IRQ_RISE]) |
              (r_q.cond_flag & r_q.ctrl[CB_IRQ_COND]);
        case (bus_addr)
            A_S1:    bus_rdata = {{PAD_LINE{1'b0}}, sync_l.s1};
            A_S0:    bus_rdata = {{PAD_LINE{1'b0}}, sync_l.s0};
            A_BUF:   bus_rdata = {{PAD_LINE{1'b0}}, r_q.buf_s1};
            A_CTRL:  bus_rdata = {{PAD_CTRL{1'b0}}, r_q.ctrl};
            A_STAT:  bus_rdata = {{PAD_STAT{1'b0}}, r_q.stretch, r_q.cond_flag, r_q.rise_flag};
            default: bus_rdata = '0;
        endcase
    end

    AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        en && s0_rise |=> r_q.rise_flag) else $error("rise lost"); // R5
    AST_BUF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        en && s0_rise |=> r_q.buf_s1 == $past(sync_l.s1)) else $error("capture"); // R4
    AST_FALL_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        en && s0_fall && r_q.ctrl[CB_STR_FALL] |=> r_q.stretch && pad_oe[0]) else $error("stretch"); // R7
    AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stretch && !release_req |=> r_q.stretch) else $error("early release"); // R9
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !wr_stat |=> $stable(r_q.rise_flag) && $stable(r_q.cond_flag)) else $error("flag while off"); // R11
    AST_LINE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_S0 |-> bus_rdata[DATA_W-1:1] == '0) else $error("upper bits"); // R3
endmodule

// File: tb/ssl_ctrl_tb.sv
module ssl_ctrl_tb_top;
    import ssl_pkg::*;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
    logic ext_s0 = 1'b1, ext_s1 = 1'b1, s0_pin, s1_pin, irq;
    logic [1:0] port_oe = 2'b00, port_do = 2'b00, pad_oe, pad_do;
    int n_chk = 0, n_fail = 0;
    logic [7:0] rv;

    always #(CLK_P/2) clk = ~clk;

    assign s0_pin = ext_s0 & ~(pad_oe[0] & ~pad_do[0]);
    assign s1_pin = ext_s1 & ~(pad_oe[1] & ~pad_do[1]);

    ssl_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .s0_pin(s0_pin), .s1_pin(s1_pin),
        .port_oe(port_oe), .port_do(port_do), .pad_oe(pad_oe), .pad_do(pad_do), .irq(irq));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic settle();
        tick(4);
    endtask

    task automatic pulse_s0();
        ext_s0 = 1'b0; settle();
        ext_s0 = 1'b1; settle();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3); rst_n = 1'b1; tick(1);
        // R1 reset state
        rd(A_S0, rv);   chk("R1 s0 line", rv, 8'h01);
        rd(A_S1, rv);   chk("R1 s1 line", rv, 8'h01);
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
        rd(A_STAT, rv); chk("R1 stat", rv, 8'h00);
        chk("R1 pads", {6'b0, pad_oe}, 8'h00);

        // R11 disabled: passthrough and no flags
        port_oe = 2'b10; port_do = 2'b01; #1;
        chk("R11 oe pass", {6'b0, pad_oe}, 8'h02);
        chk("R11 do pass", {6'b0, pad_do}, 8'h01);
        port_oe = 2'b00; port_do = 2'b00;
        pulse_s0();
        rd(A_STAT, rv); chk("R11 no flag off", rv, 8'h00);

        // R2 / R3 line control and read-back
        wr(A_CTRL, 8'h01);
        chk("R11 do zero on", {6'b0, pad_do}, 8'h00);
        wr(A_S1, 8'h00);
        chk("R2 s1 drive", {6'b0, pad_oe}, 8'h02);
        settle(); rd(A_S1, rv); chk("R3 s1 read low", rv, 8'h00);
        wr(A_S1, 8'hFF);
        chk("R2 s1 release", {6'b0, pad_oe}, 8'h00);
        wr(A_S0, 8'h00);
        chk("R2 s0 drive", {6'b0, pad_oe}, 8'h01);
        settle(); rd(A_S0, rv); chk("R3 s0 read low", rv, 8'h00);
        wr(A_S0, 8'h01); settle();
        ext_s1 = 1'b0; settle();
        rd(A_S1, rv); chk("R3 pin not reg", rv, 8'h00);
        ext_s1 = 1'b1; settle();
        wr(A_STAT, 8'h07);

        // R4 / R5 capture sweep
        for (int i = 0; i < 8; i++) begin
            logic v;
            v = (8'b1011_0010 >> i) & 1'b1;
            ext_s1 = v; settle();
            pulse_s0();
            rd(A_BUF, rv);  chk("R4 capture", rv, {7'b0, v});
            rd(A_STAT, rv); chk("R5 rise set", rv & 8'h01, 8'h01);
            wr(A_STAT, 8'h03);
            rd(A_STAT, rv); chk("R5 w1c", rv & 8'h01, 8'h00);
        end

        // R5 set wins over same-cycle clear
        ext_s0 = 1'b0; settle(); wr(A_STAT, 8'h07);
        ext_s0 = 1'b1; tick(2);
        wr(A_STAT, 8'h01);
        rd(A_STAT, rv); chk("R5 set wins", rv & 8'h01, 8'h01);
        wr(A_STAT, 8'h01);
        rd(A_STAT, rv); chk("R5 lone clear", rv & 8'h01, 8'h00);

        // R6 conditional polarity sweep
        for (int sel = 0; sel < 2; sel++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(A_CTRL, 8'h01 | 8'(sel << CB_COND_POL));
                ext_s0 = 1'b0; settle();
                ext_s1 = ~pol[0]; settle();
                ext_s0 = 1'b1; settle();
                wr(A_STAT, 8'h07);
                ext_s1 = pol[0]; settle();
                rd(A_STAT, rv);
                chk("R6 cond polarity", rv & 8'h02, (sel == pol) ? 8'h02 : 8'h00);
            end
        end
        wr(A_CTRL, 8'h01); wr(A_STAT, 8'h07);
        ext_s0 = 1'b0; settle(); ext_s1 = 1'b0; settle(); ext_s1 = 1'b1; settle();
        rd(A_STAT, rv); chk("R6 no cond when low", rv & 8'h02, 8'h00);
        ext_s0 = 1'b1; settle();

        // R10 irq combinations
        wr(A_STAT, 8'h07);
        pulse_s0();
        for (int e = 0; e < 4; e++) begin
            wr(A_CTRL, 8'h01 | 8'(e << CB_IRQ_RISE)); #1;
            chk("R10 rise only", {7'b0, irq}, {7'b0, e[0]});
        end
        ext_s1 = 1'b0; settle(); ext_s1 = 1'b1; settle();
        for (int e = 0; e < 4; e++) begin
            wr(A_CTRL, 8'h01 | 8'(e << CB_IRQ_RISE)); #1;
            chk("R10 both", {7'b0, irq}, {7'b0, |e[1:0]});
        end
        wr(A_STAT, 8'h01);
        for (int e = 0; e < 4; e++) begin
            wr(A_CTRL, 8'h01 | 8'(e << CB_IRQ_RISE)); #1;
            chk("R10 cond only", {7'b0, irq}, {7'b0, e[1]});
        end

        // R7 / R9 stretch on fall, release via S0 write
        wr(A_CTRL, 8'h03); wr(A_STAT, 8'h07);
        ext_s0 = 1'b0; settle();
        rd(A_STAT, rv); chk("R7 stretch flag", rv & 8'h04, 8'h04);
        chk("R7 s0 held", {7'b0, pad_oe[0]}, 8'h01);
        ext_s0 = 1'b1; settle();
        rd(A_S0, rv); chk("R7 still low", rv, 8'h00);
        wr(A_S0, 8'h01);
        chk("R9 release by s0", {7'b0, pad_oe[0]}, 8'h00);
        settle(); rd(A_S0, rv); chk("R9 s0 high", rv, 8'h01);
        rd(A_STAT, rv); chk("R9 flag off", rv & 8'h04, 8'h00);
        ext_s0 = 1'b0; settle(); ext_s0 = 1'b1;
        wr(A_STAT, 8'h04);
        chk("R9 release by w1c", {7'b0, pad_oe[0]}, 8'h00);
        settle();

        // R8 conditional stretch
        wr(A_CTRL, 8'h05); wr(A_STAT, 8'h07);
        ext_s0 = 1'b0; settle();
        rd(A_STAT, rv); chk("R8 no cond no stretch", rv & 8'h04, 8'h00);
        ext_s0 = 1'b1; settle(); wr(A_STAT, 8'h07);
        ext_s1 = 1'b0; settle();
        rd(A_STAT, rv); chk("R8 cond pending", rv & 8'h02, 8'h02);
        ext_s0 = 1'b0; settle();
        rd(A_STAT, rv); chk("R8 cond stretch", rv & 8'h04, 8'h04);
        ext_s0 = 1'b1; wr(A_STAT, 8'h06); settle();
        rd(A_S0, rv); chk("R9 released", rv, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule